// File: doc/BRIEF.md
# Stack Call/Return and Break Sequencer

This block drives the processor stack on behalf of an execution unit. Given one command per start pulse, it walks through the memory accesses needed for a subroutine call or return, a push or pull of the accumulator or status byte, entry into a software break, or a return from an interrupt. It produces the new program counter, the restored status or accumulator, and the updated stack pointer.

The stack sits in page one: every stack access goes to address `0x0100 + SP`, with an 8-bit stack pointer that grows downward. Memory is a simple byte port with a combinational read. Exactly one access is made per clock cycle. A one-cycle done pulse follows the last access, and the results are valid in that cycle.

Top module: `stk_seq`

## Requirements
- R1: A push drives `mem_we_o` with address `0x0100 + SP` and decrements SP at the end of that cycle; a pull reads address `0x0100 + SP + 1` and leaves SP incremented.
- R2: SP resets to 0xFF asynchronously, and its increment and decrement wrap within 8 bits (0xFF+1 = 0x00, 0x00-1 = 0xFF).
- R3: After reset `status_o` is 0x36 (bit order N,V,unused,B,D,I,Z,C from bit 7 down, with unused, B, I and Z set), `pc_o` is 0, `acc_o` is 0, and `busy_o` and `done_o` are low.
- R4: A call pushes the high byte of `pc_i + 2` and then its low byte, then loads `pc_o` from `target_i`.
- R5: A break pushes the high byte of `pc_i + 2`, then its low byte, then `status_i`. It then reads 0xFFFE (low byte) and 0xFFFF (high byte) into `pc_o`, and sets `status_o` to `status_i` with bit 2 (I) forced to 1.
- R6: An interrupt return pulls the status byte, then the PC low byte, then the PC high byte, and sets `pc_o` to the pulled address unchanged.
- R7: A subroutine return pulls the low byte and then the high byte, and sets `pc_o` to the pulled address plus 1.
- R8: A pulled status byte sets `status_o` bits 7:6 and 3:0 from memory, and bits 5:4 (unused and B) from `status_i`.
- R9: Pushing the accumulator writes `acc_i`; pulling it loads `acc_o`; pushing the status writes `status_i` unchanged.
- R10: The command takes one memory access per cycle. Access counts are: call 2, return 2, accumulator push and pull 1 each, status push and pull 1 each, break 5, interrupt return 3. `done_o` is high for exactly one cycle, the cycle after the last access, and makes no access.
- R11: `start_i` is ignored while `busy_o` is high; such a start causes no access and no change to SP or the outputs.
- R12: `cmd_i` encoding: 0 call, 1 subroutine return, 2 accumulator push, 3 accumulator pull, 4 status push, 5 status pull, 6 break, 7 interrupt return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start the command on `cmd_i` when idle |
| cmd_i | input | 3 | Command code |
| pc_i | input | 16 | Address of the current instruction |
| target_i | input | 16 | Call destination from the operand bytes |
| status_i | input | 8 | Current status byte |
| acc_i | input | 8 | Current accumulator |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, same cycle |
| pc_o | output | 16 | Resulting program counter |
| status_o | output | 8 | Resulting status byte |
| acc_o | output | 8 | Resulting accumulator |
| sp_o | output | 8 | Stack pointer |
| busy_o | output | 1 | Command in progress (includes done cycle) |
| done_o | output | 1 | Command complete, results valid |

## Verification
The bench runs a chained program through a memory model. It covers a call whose return address is later pulled back with the +1 correction, and a break whose three pushed bytes are consumed by an interrupt return. A design that swapped the byte order, or applied the +1 on the wrong return, would land on a wrong `pc_o`. A status pull is set up so that memory and `status_i` disagree in bits 5:4; copying all eight bits from memory shows up as a wrong `status_o`. Pulls at SP 0xFF and pushes at SP 0x00 expose missing 8-bit wrap. A start issued mid-command, and a reset applied in the middle of a break, catch a sequencer that restarts or keeps partial state.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    CMD_CALL   = 3'd0,
    CMD_RET    = 3'd1,
    CMD_PUSH_A = 3'd2,
    CMD_PULL_A = 3'd3,
    CMD_PUSH_S = 3'd4,
    CMD_PULL_S = 3'd5,
    CMD_BRK    = 3'd6,
    CMD_RTI    = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    ACC_WR_STACK = 2'd0,
    ACC_RD_STACK = 2'd1,
    ACC_RD_VEC   = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    SRC_PCH  = 2'd0,
    SRC_PCL  = 2'd1,
    SRC_ACC  = 2'd2,
    SRC_STAT = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    DST_NONE = 3'd0,
    DST_LO   = 3'd1,
    DST_HI   = 3'd2,
    DST_ACC  = 3'd3,
    DST_STAT = 3'd4
  } dst_e;

  typedef struct packed {
    kind_e kind;
    src_e  src;
    dst_e  dst;
    logic  vec_hi;
    logic  last;
  } uop_t;

  localparam int STEP_W     = 3;
  localparam int STAT_I_BIT = 2;
  localparam int STAT_B_BIT = 4;
  localparam int STAT_U_BIT = 5;

  function automatic uop_t mk_uop(kind_e k, src_e s, dst_e d, logic vh, logic l);
    uop_t u;
    u.kind   = k;
    u.src    = s;
    u.dst    = d;
    u.vec_hi = vh;
    u.last   = l;
    return u;
  endfunction
endpackage

// File: rtl/stk_uop_rom.sv
module stk_uop_rom
  import stk_pkg::*;
(
  input  cmd_e              cmd_i,
  input  logic [STEP_W-1:0] step_i,
  output uop_t              uop_o
);
  always_comb begin
    uop_o = mk_uop(ACC_RD_STACK, SRC_ACC, DST_NONE, 1'b0, 1'b1);
    unique case (cmd_i)
      CMD_CALL: begin
        if (step_i == 3'd0) uop_o = mk_uop(ACC_WR_STACK, SRC_PCH, DST_NONE, 1'b0, 1'b0);
        else                uop_o = mk_uop(ACC_WR_STACK, SRC_PCL, DST_NONE, 1'b0, 1'b1);
      end
      CMD_RET: begin
        if (step_i == 3'd0) uop_o = mk_uop(ACC_RD_STACK, SRC_ACC, DST_LO, 1'b0, 1'b0);
        else                uop_o = mk_uop(ACC_RD_STACK, SRC_ACC, DST_HI, 1'b0, 1'b1);
      end
      CMD_PUSH_A: uop_o = mk_uop(ACC_WR_STACK, SRC_ACC,  DST_NONE, 1'b0, 1'b1);
      CMD_PULL_A: uop_o = mk_uop(ACC_RD_STACK, SRC_ACC,  DST_ACC,  1'b0, 1'b1);
      CMD_PUSH_S: uop_o = mk_uop(ACC_WR_STACK, SRC_STAT, DST_NONE, 1'b0, 1'b1);
      CMD_PULL_S: uop_o = mk_uop(ACC_RD_STACK, SRC_ACC,  DST_STAT, 1'b0, 1'b1);
      CMD_BRK: begin
        unique case (step_i)
          3'd0:    uop_o = mk_uop(ACC_WR_STACK, SRC_PCH,  DST_NONE, 1'b0, 1'b0);
          3'd1:    uop_o = mk_uop(ACC_WR_STACK, SRC_PCL,  DST_NONE, 1'b0, 1'b0);
          3'd2:    uop_o = mk_uop(ACC_WR_STACK, SRC_STAT, DST_NONE, 1'b0, 1'b0);
          3'd3:    uop_o = mk_uop(ACC_RD_VEC,   SRC_ACC,  DST_LO,   1'b0, 1'b0);
          default: uop_o = mk_uop(ACC_RD_VEC,   SRC_ACC,  DST_HI,   1'b1, 1'b1);
        endcase
      end
      CMD_RTI: begin
        unique case (step_i)
          3'd0:    uop_o = mk_uop(ACC_RD_STACK, SRC_ACC, DST_STAT, 1'b0, 1'b0);
          3'd1:    uop_o = mk_uop(ACC_RD_STACK, SRC_ACC, DST_LO,   1'b0, 1'b0);
          default: uop_o = mk_uop(ACC_RD_STACK, SRC_ACC, DST_HI,   1'b0, 1'b1);
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int         SP_W     = 8,
  parameter logic [7:0] SP_RESET = 8'hFF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pull_i,
  output logic [SP_W-1:0] sp_o,
  output logic [SP_W-1:0] sp_inc_o
);
  logic [SP_W-1:0] sp_q;

  assign sp_inc_o = sp_q + SP_W'(1);
  assign sp_o     = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= SP_W'(SP_RESET);
    else if (push_i) sp_q <= sp_q - SP_W'(1);
    else if (pull_i) sp_q <= sp_inc_o;
  end
endmodule

// File: rtl/stk_result.sv
module stk_result
  import stk_pkg::*;
#(
  parameter int         DW           = 8,
  parameter logic [7:0] STATUS_RESET = 8'h36,
  localparam int        PC_W         = 2 * DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_valid_i,
  input  logic            finish_i,
  input  dst_e            dst_i,
  input  cmd_e            cmd_i,
  input  logic [DW-1:0]   rdata_i,
  input  logic [DW-1:0]   stat_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o,
  output logic [DW-1:0]   status_o,
  output logic [DW-1:0]   acc_o
);
  logic [DW-1:0]   lo_q;
  logic [PC_W-1:0] pulled_pc;
  logic [DW-1:0]   merged_stat;

  assign pulled_pc = {rdata_i, lo_q};

  // bits 5:4 are not restored from the stack
  always_comb begin
    merged_stat             = rdata_i;
    merged_stat[STAT_U_BIT] = stat_i[STAT_U_BIT];
    merged_stat[STAT_B_BIT] = stat_i[STAT_B_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      pc_o     <= '0;
      status_o <= DW'(STATUS_RESET);
      acc_o    <= '0;
    end else begin
      if (rd_valid_i) begin
        unique case (dst_i)
          DST_LO:   lo_q     <= rdata_i;
          DST_ACC:  acc_o    <= rdata_i;
          DST_STAT: status_o <= merged_stat;
          DST_HI:   pc_o     <= (cmd_i == CMD_RET) ? pulled_pc + PC_W'(1) : pulled_pc;
          default: ;
        endcase
      end
      if (finish_i && cmd_i == CMD_CALL) pc_o <= target_i;
      if (finish_i && cmd_i == CMD_BRK) begin
        status_o             <= stat_i;
        status_o[STAT_I_BIT] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int          DW           = 8,
  parameter int          AW           = 16,
  parameter logic [7:0]  STACK_PAGE   = 8'h01,
  parameter logic [15:0] VEC_BASE     = 16'hFFFE,
  parameter logic [7:0]  SP_RESET     = 8'hFF,
  parameter logic [7:0]  STATUS_RESET = 8'h36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    cmd_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] target_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] acc_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] sp_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int SP_W = AW - DW;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  cmd_e              cmd_q;
  logic [AW-1:0]     ret_q;
  logic [AW-1:0]     tgt_q;
  logic [DW-1:0]     stat_q;
  logic [DW-1:0]     acc_q;
  uop_t              uop;
  logic              in_run;
  logic [SP_W-1:0]   sp, sp_inc;

  stk_uop_rom u_rom (
    .cmd_i  (cmd_q),
    .step_i (step_q),
    .uop_o  (uop)
  );

  assign in_run = (state_q == ST_RUN);

  stk_ptr #(.SP_W(SP_W), .SP_RESET(SP_RESET)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (in_run && uop.kind == ACC_WR_STACK),
    .pull_i   (in_run && uop.kind == ACC_RD_STACK),
    .sp_o     (sp),
    .sp_inc_o (sp_inc)
  );

  stk_result #(.DW(DW), .STATUS_RESET(STATUS_RESET)) u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_valid_i (in_run && uop.kind != ACC_WR_STACK),
    .finish_i   (in_run && uop.last),
    .dst_i      (uop.dst),
    .cmd_i      (cmd_q),
    .rdata_i    (mem_rdata_i),
    .stat_i     (stat_q),
    .target_i   (tgt_q),
    .pc_o       (pc_o),
    .status_o   (status_o),
    .acc_o      (acc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      cmd_q   <= CMD_CALL;
      ret_q   <= '0;
      tgt_q   <= '0;
      stat_q  <= '0;
      acc_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          step_q  <= '0;
          cmd_q   <= cmd_e'(cmd_i);
          ret_q   <= pc_i + AW'(2);
          tgt_q   <= target_i;
          stat_q  <= status_i;
          acc_q   <= acc_i;
        end
        ST_RUN: begin
          if (uop.last) state_q <= ST_DONE;
          else          step_q  <= step_q + STEP_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (uop.kind)
      ACC_WR_STACK: mem_addr_o = {STACK_PAGE, sp};
      ACC_RD_STACK: mem_addr_o = {STACK_PAGE, sp_inc};
      default:      mem_addr_o = VEC_BASE + AW'(uop.vec_hi);
    endcase
    unique case (uop.src)
      SRC_PCH:  mem_wdata_o = ret_q[AW-1:DW];
      SRC_PCL:  mem_wdata_o = ret_q[DW-1:0];
      SRC_STAT: mem_wdata_o = stat_q;
      default:  mem_wdata_o = acc_q;
    endcase
  end

  assign mem_req_o = in_run;
  assign mem_we_o  = in_run && uop.kind == ACC_WR_STACK;
  assign sp_o      = sp;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int         DW         = 8,
  parameter int         AW         = 16,
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] sp_o,
  input logic          done_o,
  input logic          busy_o
);
  AST_PUSH_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> sp_o == $past(sp_o) - DW'(1)); // R1
  AST_PULL_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_addr_o[AW-1:DW] == STACK_PAGE) |=> sp_o == $past(sp_o) + DW'(1)); // R1
  AST_PUSH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o == {STACK_PAGE, sp_o}); // R1
  AST_SP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o |=> $stable(sp_o)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o); // R10
  AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R10
endmodule

bind stk_seq stk_seq_chk #(.DW(DW), .AW(AW), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .sp_o       (sp_o),
  .done_o     (done_o),
  .busy_o     (busy_o)
);

// File: tb/stk_seq_test.sv
module stk_seq_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  cmd;
    logic [15:0] pc;
    logic [7:0]  st;
    logic [7:0]  acc;
    logic [15:0] tgt;
    logic [15:0] e_pc;
    logic [7:0]  e_st;
    logic [7:0]  e_acc;
    logic [7:0]  e_sp;
    logic [3:0]  n_acc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'h1234, 8'h00, 8'h00, 16'hABCD, 16'hABCD, 8'h36, 8'h00, 8'hFD, 4'd2}, // R4 call
    '{3'd2, 16'h0000, 8'h00, 8'h5A, 16'h0000, 16'hABCD, 8'h36, 8'h00, 8'hFC, 4'd1}, // R9 push acc
    '{3'd4, 16'h0000, 8'hC3, 8'h00, 16'h0000, 16'hABCD, 8'h36, 8'h00, 8'hFB, 4'd1}, // R9 push status
    '{3'd5, 16'h0000, 8'h30, 8'h00, 16'h0000, 16'hABCD, 8'hF3, 8'h00, 8'hFC, 4'd1}, // R8 pull status
    '{3'd3, 16'h0000, 8'h00, 8'h00, 16'h0000, 16'hABCD, 8'hF3, 8'h5A, 8'hFD, 4'd1}, // R9 pull acc
    '{3'd1, 16'h0000, 8'h00, 8'h00, 16'h0000, 16'h1237, 8'hF3, 8'h5A, 8'hFF, 4'd2}, // R7 return
    '{3'd6, 16'h2000, 8'h81, 8'h00, 16'h0000, 16'h9080, 8'h85, 8'h5A, 8'hFC, 4'd5}, // R5 break
    '{3'd7, 16'h0000, 8'h00, 8'h00, 16'h0000, 16'h2002, 8'h81, 8'h5A, 8'hFF, 4'd3}, // R6 int return
    '{3'd3, 16'h0000, 8'h00, 8'h00, 16'h0000, 16'h2002, 8'h81, 8'h11, 8'h00, 4'd1}, // R2 wrap up
    '{3'd2, 16'h0000, 8'h00, 8'h77, 16'h0000, 16'h2002, 8'h81, 8'h11, 8'hFF, 4'd1}  // R2 wrap down
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic [15:0] pc_i = '0, target_i = '0;
  logic [7:0]  status_i = '0, acc_i = '0;
  logic        mem_req_o, mem_we_o, busy_o, done_o;
  logic [15:0] mem_addr_o, pc_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i, status_o, acc_o, sp_o;

  logic [7:0]  stk [256];
  int          checks = 0;
  int          errors = 0;
  int          naccess;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  stk_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmd_i(cmd_i),
    .pc_i(pc_i), .target_i(target_i), .status_i(status_i), .acc_i(acc_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .pc_o(pc_o), .status_o(status_o), .acc_o(acc_o), .sp_o(sp_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // memory model: page one plus the break vector
  always_comb begin
    if (mem_addr_o[15:8] == 8'h01) mem_rdata_i = stk[mem_addr_o[7:0]];
    else if (mem_addr_o == 16'hFFFE) mem_rdata_i = 8'h80;
    else if (mem_addr_o == 16'hFFFF) mem_rdata_i = 8'h90;
    else mem_rdata_i = 8'h00;
  end

  always @(posedge clk_i) begin
    if (mem_req_o && mem_we_o && mem_addr_o[15:8] == 8'h01) stk[mem_addr_o[7:0]] <= mem_wdata_o;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] c, input logic [15:0] pc, input logic [7:0] st,
                         input logic [7:0] acc, input logic [15:0] tgt, input bit extra_start);
    int guard;
    @(negedge clk_i);
    start_i = 1'b1; cmd_i = c; pc_i = pc; status_i = st; acc_i = acc; target_i = tgt;
    @(negedge clk_i);
    start_i = 1'b0;
    naccess = 0;
    guard = 0;
    if (extra_start) begin
      start_i = 1'b1; cmd_i = 3'd2; acc_i = 8'h99;
    end
    while (!done_o && guard < 50) begin
      if (mem_req_o) naccess++;
      @(negedge clk_i);
      start_i = 1'b0;
      guard++;
    end
    if (guard >= 50) begin
      errors++;
      $display("FAIL R10: watchdog, done never seen");
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'(i) + 8'h11;
    #(CLK_PERIOD * 2 + 2);
    // R3 / R2 reset state
    check("R2 sp reset", {8'h0, sp_o}, 16'h00FF);
    check("R3 status reset", {8'h0, status_o}, 16'h0036);
    check("R3 pc reset", pc_o, 16'h0000);
    check("R3 acc reset", {8'h0, acc_o}, 16'h0000);
    check("R3 idle", {14'h0, busy_o, done_o}, 16'h0000);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run_cmd(VECS[v].cmd, VECS[v].pc, VECS[v].st, VECS[v].acc, VECS[v].tgt, 1'b0);
      check($sformatf("R12 vec%0d pc", v), pc_o, VECS[v].e_pc);
      check($sformatf("R8 vec%0d status", v), {8'h0, status_o}, {8'h0, VECS[v].e_st});
      check($sformatf("R9 vec%0d acc", v), {8'h0, acc_o}, {8'h0, VECS[v].e_acc});
      check($sformatf("R1 vec%0d sp", v), {8'h0, sp_o}, {8'h0, VECS[v].e_sp});
      check($sformatf("R10 vec%0d accesses", v), 16'(naccess), {12'h0, VECS[v].n_acc});
      if (v == 0) begin
        check("R4 call high byte first", {8'h0, stk[8'hFF]}, 16'h0012);
        check("R4 call low byte second", {8'h0, stk[8'hFE]}, 16'h0036);
      end
      if (v == 6) begin
        check("R5 break pc high", {8'h0, stk[8'hFF]}, 16'h0020);
        check("R5 break pc low", {8'h0, stk[8'hFE]}, 16'h0002);
        check("R5 break status", {8'h0, stk[8'hFD]}, 16'h0081);
      end
      if (v == 9) check("R2 push at sp 00", {8'h0, stk[8'h00]}, 16'h0077);
      @(negedge clk_i);
      check($sformatf("R10 vec%0d done pulse", v), {15'h0, done_o}, 16'h0000);
    end

    // R11: a start during a running call is ignored
    run_cmd(3'd0, 16'h4000, 8'h00, 8'h00, 16'h5555, 1'b1);
    check("R11 pc after busy start", pc_o, 16'h5555);
    check("R11 sp after busy start", {8'h0, sp_o}, 16'h00FD);
    check("R11 access count", 16'(naccess), 16'd2);
    repeat (3) @(negedge clk_i);
    check("R11 still idle", {15'h0, busy_o}, 16'h0000);
    check("R11 sp unchanged", {8'h0, sp_o}, 16'h00FD);
    check("R11 acc unchanged", {8'h0, acc_o}, 16'h0011);
    check("R11 no stray push", {8'h0, stk[8'hFD]}, 16'h0081);

    // R2/R3: reset in the middle of a break
    @(negedge clk_i);
    start_i = 1'b1; cmd_i = 3'd6; pc_i = 16'h3000; status_i = 8'h00;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R2 sp after mid reset", {8'h0, sp_o}, 16'h00FF);
    check("R3 pc after mid reset", pc_o, 16'h0000);
    check("R3 status after mid reset", {8'h0, status_o}, 16'h0036);
    check("R3 busy after mid reset", {15'h0, busy_o}, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R11 no access after reset", {15'h0, mem_req_o}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R10: global watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule